// File: doc/BRIEF.md
# Stream Fork with Per-Output Bit Selection

This block copies one incoming AXI4-Stream onto a parameterised number of outgoing streams, from one to sixteen. It holds no state. A beat crosses the block only in a cycle in which every downstream port is ready. Each output's valid is masked by the readiness of all the other outputs, so no consumer can complete a handshake on a beat that a sibling cannot take in the same cycle. As a result, each output sees each input beat exactly once.

Each output has its own window onto the input. Parameters give a low-bit offset and a width for the data field, and another offset and width for the user field. The byte-enable field follows the data window at byte granularity, so outputs may be narrower than the input and may differ from each other. The packet-end flag is copied to every output. All outputs are packed into wide ports: output 0 sits in the lowest slice and each later output sits directly above the one before it. An illegal configuration stops elaboration. This covers an output count outside 1..16, a window that runs past the input bus, a zero width, and a data window that is not byte aligned.

Top module: `stream_fork`

## Requirements
- R1: NUM_OUT may be any value from 1 to 16. With NUM_OUT = 1 the output equals the input on every field and handshake signal, and s_ready equals m_ready.
- R2: s_ready is 1 exactly when every bit of m_ready is 1.
- R3: m_valid[i] is 1 exactly when s_valid is 1 and every m_ready bit other than bit i is 1. While s_valid is 0, m_valid is all zeros.
- R4: Output slices are packed upward from bit 0 in output order. Output k's data starts at the sum of the data widths of outputs 0..k-1. The same rule applies to the user and keep ports, using their own widths.
- R5: Output i's data equals s_data[DATA_LO_i +: DATA_W_i]. A window with zero width, with a start or width not a multiple of 8, or reaching past IN_DW fails elaboration.
- R6: Output i's user field equals s_user[USER_LO_i +: USER_W_i]. A window with zero width or reaching past IN_UW fails elaboration.
- R7: m_last[i] equals s_last for every output i.
- R8: Output i's keep field has DATA_W_i/8 bits and equals s_keep[DATA_LO_i/8 +: DATA_W_i/8]. Keep bit j qualifies data bits 8j+7..8j.
- R9: Under any pattern of downstream readiness, each beat accepted at the input (s_valid and s_ready both 1) appears exactly once on every output, with that output's selected bits. No output completes a handshake on any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_valid | input | 1 | Incoming beat valid |
| s_ready | output | 1 | Incoming beat accepted when high with s_valid |
| s_data | input | IN_DW | Incoming data |
| s_keep | input | IN_DW/8 | Incoming byte enables |
| s_user | input | IN_UW | Incoming sideband |
| s_last | input | 1 | Incoming packet-end flag |
| m_valid | output | NUM_OUT | Per-output valid, one bit per output |
| m_ready | input | NUM_OUT | Per-output ready, one bit per output |
| m_data | output | sum of DATA_W_i | Packed output data, output 0 lowest |
| m_keep | output | sum of DATA_W_i/8 | Packed output byte enables |
| m_user | output | sum of USER_W_i | Packed output sideband |
| m_last | output | NUM_OUT | Packet-end flag copied per output |

## Verification
The assertions take for granted that every input settles to a known level. They are skipped while any handshake or payload input is unknown. They also assume that no downstream ready depends combinationally on the valid it receives, since such a loop would leave the handshake unsettled. The bench draws each ready bit at random each cycle, without reference to the valids. It holds each source beat unchanged until the cycle it is accepted. It samples the outputs mid-cycle, after the inputs have settled.

// File: rtl/stream_fork_pkg.sv
package stream_fork_pkg;

    localparam int MAX_OUT  = 16;
    localparam int CFG_BITS = 8;

    // One 8-bit field per output, output 0 in the low byte.
    typedef logic [MAX_OUT*CFG_BITS-1:0] fork_cfg_t;

    function automatic int cfg_at(input fork_cfg_t cfg, input int idx);
        return int'(cfg[idx*CFG_BITS +: CFG_BITS]);
    endfunction

    // Sum of the first n fields: base of field n in a packed port.
    function automatic int cfg_sum(input fork_cfg_t cfg, input int n);
        int acc;
        acc = 0;
        for (int k = 0; k < n && k < MAX_OUT; k++) begin
            acc += cfg_at(cfg, k);
        end
        return acc;
    endfunction

    // Same sum in bytes, used for the keep port.
    function automatic int cfg_byte_sum(input fork_cfg_t cfg, input int n);
        int acc;
        acc = 0;
        for (int k = 0; k < n && k < MAX_OUT; k++) begin
            acc += cfg_at(cfg, k) / 8;
        end
        return acc;
    endfunction

    // Every window non-empty, inside the bus, optionally byte aligned.
    function automatic bit cfg_fits(input fork_cfg_t lo, input fork_cfg_t w,
                                    input int n, input int limit,
                                    input bit need_bytes);
        bit ok;
        ok = 1'b1;
        for (int k = 0; k < n && k < MAX_OUT; k++) begin
            if (cfg_at(w, k) == 0) ok = 1'b0;
            if (cfg_at(lo, k) + cfg_at(w, k) > limit) ok = 1'b0;
            if (need_bytes && ((cfg_at(lo, k) % 8) != 0 || (cfg_at(w, k) % 8) != 0)) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/stream_fork_hs.sv
module stream_fork_hs #(
    parameter int NUM_OUT = 2
) (
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [NUM_OUT-1:0] m_ready,
    output logic [NUM_OUT-1:0] m_valid
);

    generate
        if (NUM_OUT == 1) begin : g_wire
            // Single output: handshake passes straight through (R1).
            assign s_ready    = m_ready[0];
            assign m_valid[0] = s_valid;
        end else begin : g_fan
            assign s_ready = &m_ready;
            for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
                localparam logic [NUM_OUT-1:0] SELF = NUM_OUT'(1) << i;
                // Own ready is forced high in the mask, so only siblings gate it.
                assign m_valid[i] = s_valid & (&(m_ready | SELF));
            end
        end
    endgenerate

endmodule

// File: rtl/stream_fork_lane.sv
module stream_fork_lane #(
    parameter int IN_DW = 32,
    parameter int IN_UW = 8,
    parameter int D_LO  = 0,
    parameter int D_W   = 32,
    parameter int U_LO  = 0,
    parameter int U_W   = 8
) (
    input  logic [IN_DW-1:0]   s_data,
    input  logic [IN_DW/8-1:0] s_keep,
    input  logic [IN_UW-1:0]   s_user,
    input  logic               s_last,
    output logic [D_W-1:0]     o_data,
    output logic [D_W/8-1:0]   o_keep,
    output logic [U_W-1:0]     o_user,
    output logic               o_last
);

    localparam int K_LO = D_LO / 8;
    localparam int K_W  = D_W / 8;

    assign o_data = s_data[D_LO +: D_W];
    assign o_keep = s_keep[K_LO +: K_W];
    assign o_user = s_user[U_LO +: U_W];
    assign o_last = s_last;

endmodule

// File: rtl/stream_fork.sv
module stream_fork
    import stream_fork_pkg::*;
#(
    parameter int        NUM_OUT = 2,
    parameter int        IN_DW   = 32,
    parameter int        IN_UW   = 8,
    parameter fork_cfg_t DATA_LO = '0,
    parameter fork_cfg_t DATA_W  = {MAX_OUT{8'd32}},
    parameter fork_cfg_t USER_LO = '0,
    parameter fork_cfg_t USER_W  = {MAX_OUT{8'd8}},
    localparam int       IN_KW   = IN_DW / 8,
    localparam int       TOT_DW  = cfg_sum(DATA_W, NUM_OUT),
    localparam int       TOT_KW  = cfg_byte_sum(DATA_W, NUM_OUT),
    localparam int       TOT_UW  = cfg_sum(USER_W, NUM_OUT)
) (
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [IN_DW-1:0]   s_data,
    input  logic [IN_KW-1:0]   s_keep,
    input  logic [IN_UW-1:0]   s_user,
    input  logic               s_last,
    output logic [NUM_OUT-1:0] m_valid,
    input  logic [NUM_OUT-1:0] m_ready,
    output logic [TOT_DW-1:0]  m_data,
    output logic [TOT_KW-1:0]  m_keep,
    output logic [TOT_UW-1:0]  m_user,
    output logic [NUM_OUT-1:0] m_last
);

    // Elaboration guard for R1, R5, R6.
    localparam bit CFG_OK = (NUM_OUT >= 1) && (NUM_OUT <= MAX_OUT) && (IN_DW % 8 == 0)
                          && cfg_fits(DATA_LO, DATA_W, NUM_OUT, IN_DW, 1'b1)
                          && cfg_fits(USER_LO, USER_W, NUM_OUT, IN_UW, 1'b0);

    generate
        if (!CFG_OK) begin : g_cfg_bad
            $fatal(1, "stream_fork: output count or a bit window is out of range");
        end
    endgenerate

    stream_fork_hs #(.NUM_OUT(NUM_OUT)) u_hs (
        .s_valid (s_valid),
        .s_ready (s_ready),
        .m_ready (m_ready),
        .m_valid (m_valid)
    );

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
            localparam int DB = cfg_sum(DATA_W, i);
            localparam int KB = cfg_byte_sum(DATA_W, i);
            localparam int UB = cfg_sum(USER_W, i);
            localparam int DW = cfg_at(DATA_W, i);
            localparam int UW = cfg_at(USER_W, i);

            stream_fork_lane #(
                .IN_DW (IN_DW),
                .IN_UW (IN_UW),
                .D_LO  (cfg_at(DATA_LO, i)),
                .D_W   (DW),
                .U_LO  (cfg_at(USER_LO, i)),
                .U_W   (UW)
            ) u_lane (
                .s_data (s_data),
                .s_keep (s_keep),
                .s_user (s_user),
                .s_last (s_last),
                .o_data (m_data[DB +: DW]),
                .o_keep (m_keep[KB +: DW/8]),
                .o_user (m_user[UB +: UW]),
                .o_last (m_last[i])
            );
        end
    endgenerate

endmodule

// File: rtl/stream_fork_chk.sv
module stream_fork_chk
    import stream_fork_pkg::*;
#(
    parameter int        NUM_OUT = 2,
    parameter int        IN_DW   = 32,
    parameter int        IN_UW   = 8,
    parameter fork_cfg_t DATA_LO = '0,
    parameter fork_cfg_t DATA_W  = {MAX_OUT{8'd32}},
    parameter fork_cfg_t USER_LO = '0,
    parameter fork_cfg_t USER_W  = {MAX_OUT{8'd8}},
    localparam int       IN_KW   = IN_DW / 8,
    localparam int       TOT_DW  = cfg_sum(DATA_W, NUM_OUT),
    localparam int       TOT_KW  = cfg_byte_sum(DATA_W, NUM_OUT),
    localparam int       TOT_UW  = cfg_sum(USER_W, NUM_OUT)
) (
    input logic               s_valid,
    input logic               s_ready,
    input logic [IN_DW-1:0]   s_data,
    input logic [IN_KW-1:0]   s_keep,
    input logic [IN_UW-1:0]   s_user,
    input logic               s_last,
    input logic [NUM_OUT-1:0] m_valid,
    input logic [NUM_OUT-1:0] m_ready,
    input logic [TOT_DW-1:0]  m_data,
    input logic [TOT_KW-1:0]  m_keep,
    input logic [TOT_UW-1:0]  m_user,
    input logic [NUM_OUT-1:0] m_last
);

    logic hs_known;
    assign hs_known = !$isunknown({s_valid, m_ready});

    always_comb begin
        if (hs_known) begin
            a_r2_ready_all: assert (s_ready == (m_ready == '1))
                else $error("R2: input ready disagrees with downstream readies");
            a_r3_idle_quiet: assert (s_valid || (m_valid == '0))
                else $error("R3: output valid without input valid");
            a_r9_full_fanout: assert (!(s_valid && s_ready) || (m_valid == '1))
                else $error("R9: accepted beat not offered on every output");
        end
    end

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
            localparam int DB = cfg_sum(DATA_W, i);
            localparam int KB = cfg_byte_sum(DATA_W, i);
            localparam int UB = cfg_sum(USER_W, i);
            localparam int DW = cfg_at(DATA_W, i);
            localparam int UW = cfg_at(USER_W, i);
            localparam int DL = cfg_at(DATA_LO, i);
            localparam int UL = cfg_at(USER_LO, i);

            always_comb begin
                if (hs_known) begin
                    a_r3_no_lone_beat: assert (!(m_valid[i] && m_ready[i]) || (m_ready == '1))
                        else $error("R3: output %0d handshakes while a sibling stalls", i);
                end
                if (!$isunknown({s_data, s_keep, s_user, s_last})) begin
                    a_r5_data_window: assert (m_data[DB +: DW] == s_data[DL +: DW])
                        else $error("R5: output %0d data window wrong", i);
                    a_r8_keep_window: assert (m_keep[KB +: DW/8] == s_keep[DL/8 +: DW/8])
                        else $error("R8: output %0d keep window wrong", i);
                    a_r6_user_window: assert (m_user[UB +: UW] == s_user[UL +: UW])
                        else $error("R6: output %0d user window wrong", i);
                    a_r7_last_copy: assert (m_last[i] == s_last)
                        else $error("R7: output %0d end flag wrong", i);
                end
            end
        end
    endgenerate

endmodule

bind stream_fork stream_fork_chk #(
    .NUM_OUT (NUM_OUT),
    .IN_DW   (IN_DW),
    .IN_UW   (IN_UW),
    .DATA_LO (DATA_LO),
    .DATA_W  (DATA_W),
    .USER_LO (USER_LO),
    .USER_W  (USER_W)
) u_chk (
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .s_keep  (s_keep),
    .s_user  (s_user),
    .s_last  (s_last),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_keep  (m_keep),
    .m_user  (m_user),
    .m_last  (m_last)
);

// File: tb/sim_stream_fork.sv
module sim_stream_fork;
    import stream_fork_pkg::*;

    localparam int N = 3;
    localparam fork_cfg_t P_DLO = {{13{8'd0}}, 8'd16, 8'd8, 8'd0};
    localparam fork_cfg_t P_DW  = {{13{8'd8}}, 8'd16, 8'd24, 8'd32};
    localparam fork_cfg_t P_ULO = {{13{8'd0}}, 8'd6, 8'd4, 8'd0};
    localparam fork_cfg_t P_UW  = {{13{8'd1}}, 8'd2, 8'd4, 8'd8};

    // Bench-side view of the same configuration.
    int dlo[N] = '{0, 8, 16};
    int dw[N]  = '{32, 24, 16};
    int ulo[N] = '{0, 4, 6};
    int uw[N]  = '{8, 4, 2};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         s_valid = 1'b0;
    logic         s_ready;
    logic [31:0]  s_data = '0;
    logic [3:0]   s_keep = '0;
    logic [7:0]   s_user = '0;
    logic         s_last = 1'b0;
    logic [N-1:0] m_valid;
    logic [N-1:0] m_ready = '0;
    logic [71:0]  m_data;
    logic [8:0]   m_keep;
    logic [13:0]  m_user;
    logic [N-1:0] m_last;

    stream_fork #(
        .NUM_OUT(N), .IN_DW(32), .IN_UW(8),
        .DATA_LO(P_DLO), .DATA_W(P_DW), .USER_LO(P_ULO), .USER_W(P_UW)
    ) u0 (
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep),
        .s_user(s_user), .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .m_keep(m_keep), .m_user(m_user), .m_last(m_last)
    );

    // Single-output instance
    logic        v1_s_valid = 1'b0;
    logic        v1_s_ready;
    logic [15:0] v1_s_data = '0;
    logic [1:0]  v1_s_keep = '0;
    logic [3:0]  v1_s_user = '0;
    logic        v1_s_last = 1'b0;
    logic [0:0]  v1_m_valid;
    logic [0:0]  v1_m_ready = '0;
    logic [15:0] v1_m_data;
    logic [1:0]  v1_m_keep;
    logic [3:0]  v1_m_user;
    logic [0:0]  v1_m_last;

    stream_fork #(
        .NUM_OUT(1), .IN_DW(16), .IN_UW(4),
        .DATA_LO('0), .DATA_W({16{8'd16}}), .USER_LO('0), .USER_W({16{8'd4}})
    ) u1 (
        .s_valid(v1_s_valid), .s_ready(v1_s_ready), .s_data(v1_s_data), .s_keep(v1_s_keep),
        .s_user(v1_s_user), .s_last(v1_s_last), .m_valid(v1_m_valid), .m_ready(v1_m_ready),
        .m_data(v1_m_data), .m_keep(v1_m_keep), .m_user(v1_m_user), .m_last(v1_m_last)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic longint unsigned mask(input int w);
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic int base_of(input int i, input int which);
        int acc;
        acc = 0;
        for (int k = 0; k < i; k++) begin
            acc += (which == 0) ? dw[k] : (which == 1) ? dw[k] / 8 : uw[k];
        end
        return acc;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Compare every output window against the current inputs (R4..R8).
    task automatic check_windows(input string tag);
        for (int i = 0; i < N; i++) begin
            longint unsigned a, e;
            a = 64'(m_data >> base_of(i, 0)) & mask(dw[i]);
            e = 64'(s_data >> dlo[i]) & mask(dw[i]);
            chk(a == e, $sformatf("R4/R5 data out%0d %s", i, tag), a, e);
            a = 64'(m_keep >> base_of(i, 1)) & mask(dw[i] / 8);
            e = 64'(s_keep >> (dlo[i] / 8)) & mask(dw[i] / 8);
            chk(a == e, $sformatf("R8 keep out%0d %s", i, tag), a, e);
            a = 64'(m_user >> base_of(i, 2)) & mask(uw[i]);
            e = 64'(s_user >> ulo[i]) & mask(uw[i]);
            chk(a == e, $sformatf("R6 user out%0d %s", i, tag), a, e);
            chk(m_last[i] == s_last, $sformatf("R7 last out%0d %s", i, tag), 64'(m_last[i]), 64'(s_last));
        end
    endtask

    task automatic t_idle();
        step();
        s_valid = 1'b0;
        m_ready = '1;
        #3;
        chk(m_valid == '0, "R3 idle valids", 64'(m_valid), 0);
        chk(s_ready == 1'b1, "R2 idle ready", 64'(s_ready), 1);
    endtask

    task automatic t_ready_combos();
        for (int r = 0; r < (1 << N); r++) begin
            step();
            s_valid = 1'b1;
            m_ready = N'(r);
            #3;
            chk(s_ready == (r == (1 << N) - 1), "R2 ready combo", 64'(s_ready), 64'(r == (1 << N) - 1));
            for (int i = 0; i < N; i++) begin
                bit e;
                e = ((r | (1 << i)) == (1 << N) - 1);
                chk(m_valid[i] == e, $sformatf("R3 valid out%0d ready=%0b", i, r), 64'(m_valid[i]), 64'(e));
            end
        end
        step();
        s_valid = 1'b0;
    endtask

    task automatic t_windows();
        logic [31:0] pats[5] = '{32'hFFFF_FFFF, 32'h0, 32'h1234_5678, 32'hA5C3_0F96, 32'h8000_0001};
        for (int p = 0; p < 5; p++) begin
            step();
            s_data = pats[p];
            s_keep = pats[p][3:0] ^ pats[p][7:4];
            s_user = pats[p][15:8];
            s_last = pats[p][0];
            #3;
            check_windows($sformatf("pattern %0d", p));
        end
        for (int b = 0; b < 32; b += 5) begin
            step();
            s_data = 32'd1 << b;
            s_keep = 4'd1 << (b / 8);
            s_user = 8'd1 << (b % 8);
            s_last = b[0];
            #3;
            check_windows($sformatf("walk bit %0d", b));
        end
    endtask

    // Random backpressure stream (R9).
    task automatic t_stream();
        localparam int BEATS = 60;
        logic [31:0] beat_d[BEATS];
        logic [7:0]  beat_u[BEATS];
        int got[N];
        int k;
        int cyc;
        for (int j = 0; j < BEATS; j++) begin
            beat_d[j] = $urandom;
            beat_u[j] = 8'($urandom);
        end
        for (int i = 0; i < N; i++) got[i] = 0;
        k = 0;
        cyc = 0;
        while (k < BEATS && cyc < 5000) begin
            step();
            cyc++;
            s_valid = ($urandom % 4) != 0;
            s_data  = beat_d[k];
            s_user  = beat_u[k];
            s_keep  = beat_d[k][3:0];
            s_last  = (k % 7) == 6;
            m_ready = N'($urandom);
            #3;
            for (int i = 0; i < N; i++) begin
                if (m_valid[i] && m_ready[i]) begin
                    longint unsigned a, e;
                    chk(m_ready == '1, $sformatf("R9 lone handshake out%0d", i), 64'(m_ready), 64'((1 << N) - 1));
                    chk(got[i] == k, $sformatf("R9 beat order out%0d", i), 64'(got[i]), 64'(k));
                    a = 64'(m_data >> base_of(i, 0)) & mask(dw[i]);
                    e = 64'(beat_d[k] >> dlo[i]) & mask(dw[i]);
                    chk(a == e, $sformatf("R9 stream data out%0d", i), a, e);
                    got[i]++;
                end
            end
            if (s_valid && s_ready) k++;
        end
        step();
        s_valid = 1'b0;
        chk(k == BEATS, "R9 all beats accepted", 64'(k), 64'(BEATS));
        for (int i = 0; i < N; i++) begin
            chk(got[i] == BEATS, $sformatf("R9 once per beat out%0d", i), 64'(got[i]), 64'(BEATS));
        end
    endtask

    task automatic t_single();
        for (int p = 0; p < 4; p++) begin
            step();
            v1_s_valid = p[0];
            v1_m_ready = p[1];
            v1_s_data  = 16'hC3A5 ^ 16'(p * 16'h1111);
            v1_s_keep  = 2'(p);
            v1_s_user  = 4'(p * 5);
            v1_s_last  = p[1];
            #3;
            chk(v1_m_valid[0] == v1_s_valid, "R1 single valid", 64'(v1_m_valid), 64'(v1_s_valid));
            chk(v1_s_ready == v1_m_ready[0], "R1 single ready", 64'(v1_s_ready), 64'(v1_m_ready));
            chk(v1_m_data == v1_s_data, "R1 single data", 64'(v1_m_data), 64'(v1_s_data));
            chk({v1_m_keep, v1_m_user, v1_m_last} == {v1_s_keep, v1_s_user, v1_s_last},
                "R1 single side fields", 64'({v1_m_keep, v1_m_user, v1_m_last}),
                64'({v1_s_keep, v1_s_user, v1_s_last}));
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #200;
        t_idle();
        t_ready_combos();
        t_windows();
        t_stream();
        t_single();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule